// File: doc/BRIEF.md
# Serial-Link Power-Up Sequencer

This block brings a serial-link controller and its PHY out of reset in a safe order. On a start command it turns on the PHY, bus and core clock enables one cycle apart. It then takes the PHY out of power-down. After a short settling delay it gates the reference clock on, so that the PHY's internally synchronised reset lasts long enough. It then waits for the clocks to stabilise and drives a pulse on the external endpoint reset pin.

After the pin is released, one of two finishing modes runs. In lock mode the PHY reset is released and a PLL-locked input is polled a bounded number of times. In soft-reset mode the core soft reset is released and a final settling delay runs. A shutdown command returns every output to its reset value from any state.

All delays are counted in microsecond ticks taken from a prescaler of `TICK_DIV` clock cycles. A simulation can therefore shrink them by changing parameters.

Top module: `lnk_pwrup_seq`

## Requirements
- R1: During and after reset, and in idle, the outputs are: `phy_pwrdn_o`=1, `refclk_en_o`=0, all three clock enables 0, `phy_rst_o`=1, `core_srst_o`=1, `ep_rst_pin_o` at its inactive level, `done_o`=0 and `lock_timeout_o`=0.
- R2: A `start_i` seen in idle at edge S sets `phy_clk_en_o` at S, `bus_clk_en_o` at S+1 and `core_clk_en_o` at S+2.
- R3: `phy_pwrdn_o` falls at S+3. `refclk_en_o` rises `T_REF_US*TICK_DIV+1` cycles later.
- R4: `ep_rst_pin_o` goes to its active level `T_STABLE_US*TICK_DIV+1` cycles after `refclk_en_o` rises. It returns to its inactive level `T_PIN_US*TICK_DIV+1` cycles after that.
- R5: The pin's active level equals `pin_pol_i` (1 means active high) and its inactive level is the inverse. The pin is registered and follows a change of `pin_pol_i` at the next edge.
- R6: When `lock_mode_i`=1 at pin release, `phy_rst_o` falls on the same edge as the pin release and `core_srst_o` stays 1.
- R7: In lock mode, `pll_locked_i` is sampled once every `Q = T_POLL_US*TICK_DIV+1` cycles. Sample k is taken at release+k·Q. `done_o` rises at the first sample edge that sees lock high.
- R8: If all `N_POLL` samples see no lock, `lock_timeout_o` rises at release+`N_POLL`·Q. In that case `done_o` stays 0 and the flag holds until shutdown.
- R9: When `lock_mode_i`=0 at pin release, `core_srst_o` falls with the pin release and `phy_rst_o` stays 1. `done_o` rises `T_SRST_US*TICK_DIV+1` cycles later.
- R10: `start_i` outside idle is ignored: the timing of a running sequence is unchanged, and `done_o` stays 1 until shutdown.
- R11: `shutdown_i` in any state restores the R1 values at the next edge, and it wins over a simultaneous `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin power-up sequence (idle only) |
| shutdown_i | input | 1 | Return all outputs to reset state |
| pll_locked_i | input | 1 | PHY PLL lock indication |
| pin_pol_i | input | 1 | 1: endpoint reset pin active high; 0: active low |
| lock_mode_i | input | 1 | 1: finish with PLL-lock polling; 0: finish with core soft-reset release |
| phy_pwrdn_o | output | 1 | PHY power-down |
| refclk_en_o | output | 1 | Reference-clock gate enable |
| phy_clk_en_o | output | 1 | PHY clock enable (first) |
| bus_clk_en_o | output | 1 | Bus clock enable (second) |
| core_clk_en_o | output | 1 | Core clock enable (third) |
| phy_rst_o | output | 1 | PHY reset, active high |
| core_srst_o | output | 1 | Core soft reset, active high |
| ep_rst_pin_o | output | 1 | External endpoint reset pin |
| done_o | output | 1 | Sequence finished successfully |
| lock_timeout_o | output | 1 | PLL lock not seen within the poll budget |

## Verification
Every output is a register that changes on the same edge as the sequencer state. Each step's output edge therefore falls exactly N·TICK_DIV+1 cycles after the previous one, and lock samples fall at multiples of Q after the pin release. The bench stamps the cycle at which each output changes by sampling on the falling clock edge. It compares each stamp with the expected cycle, computed from the start cycle and the parameters. The lock input is raised at a chosen offset from the predicted release, so the bench knows which sample first sees lock. Shutdown and polarity checks look one cycle after the command.

// File: rtl/lnk_pwrup_pkg.sv
package lnk_pwrup_pkg;

  // State order matters: the clock-enable and power stages are decoded
  // with ordered compares, so every later state keeps earlier enables on.
  typedef enum logic [3:0] {
    ST_IDLE        = 4'd0,
    ST_CLK_PHY     = 4'd1,
    ST_CLK_BUS     = 4'd2,
    ST_CLK_CORE    = 4'd3,
    ST_PD_WAIT     = 4'd4,
    ST_STABLE_WAIT = 4'd5,
    ST_PIN_WAIT    = 4'd6,
    ST_LOCK_POLL   = 4'd7,
    ST_DONE_LOCK   = 4'd8,
    ST_FAIL        = 4'd9,
    ST_SRST_WAIT   = 4'd10,
    ST_DONE_SOFT   = 4'd11
  } seq_state_e;

  typedef struct packed {
    logic phy_pwrdn;
    logic refclk_en;
    logic phy_clk_en;
    logic bus_clk_en;
    logic core_clk_en;
    logic phy_rst;
    logic core_srst;
    logic pin_active;
    logic done;
    logic lock_timeout;
  } seq_out_t;

  function automatic seq_out_t decode_state(seq_state_e st);
    seq_out_t o;
    o.phy_clk_en   = (st >= ST_CLK_PHY);
    o.bus_clk_en   = (st >= ST_CLK_BUS);
    o.core_clk_en  = (st >= ST_CLK_CORE);
    o.phy_pwrdn    = (st <  ST_PD_WAIT);
    o.refclk_en    = (st >= ST_STABLE_WAIT);
    o.pin_active   = (st == ST_PIN_WAIT);
    o.phy_rst      = !(st == ST_LOCK_POLL || st == ST_DONE_LOCK || st == ST_FAIL);
    o.core_srst    = !(st == ST_SRST_WAIT || st == ST_DONE_SOFT);
    o.done         = (st == ST_DONE_LOCK || st == ST_DONE_SOFT);
    o.lock_timeout = (st == ST_FAIL);
    return o;
  endfunction

endpackage

// File: rtl/lnk_us_prescaler.sv
module lnk_us_prescaler #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_pass
      logic unused_in;
      assign unused_in = clk ^ rst ^ clr_i;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pcnt_q;
      assign tick_o = (pcnt_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) pcnt_q <= '0;
        else                        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/lnk_wait_timer.sv
module lnk_wait_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         tick_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (tick_i && !expired_o) cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/lnk_poll_counter.sv
module lnk_poll_counter #(
  parameter int N_POLL = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = (N_POLL > 1) ? $clog2(N_POLL) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(N_POLL - 1));

  always_ff @(posedge clk) begin
    if (rst || clr_i)        cnt_q <= '0;
    else if (inc_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/lnk_pwrup_seq.sv
module lnk_pwrup_seq
  import lnk_pwrup_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int T_REF_US    = 10,
  parameter int T_STABLE_US = 200,
  parameter int T_PIN_US    = 100000,
  parameter int T_SRST_US   = 200,
  parameter int T_POLL_US   = 50,
  parameter int N_POLL      = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic shutdown_i,
  input  logic pll_locked_i,
  input  logic pin_pol_i,
  input  logic lock_mode_i,
  output logic phy_pwrdn_o,
  output logic refclk_en_o,
  output logic phy_clk_en_o,
  output logic bus_clk_en_o,
  output logic core_clk_en_o,
  output logic phy_rst_o,
  output logic core_srst_o,
  output logic ep_rst_pin_o,
  output logic done_o,
  output logic lock_timeout_o
);

  localparam int M1     = (T_REF_US > T_STABLE_US) ? T_REF_US : T_STABLE_US;
  localparam int M2     = (M1 > T_PIN_US) ? M1 : T_PIN_US;
  localparam int M3     = (M2 > T_SRST_US) ? M2 : T_SRST_US;
  localparam int MAX_US = (M3 > T_POLL_US) ? M3 : T_POLL_US;
  localparam int TW     = $clog2(MAX_US + 1);

  seq_state_e state_q, state_d;
  seq_out_t   out_q, out_d;
  logic       pin_q;

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          us_tick;
  logic          poll_clr, poll_inc, poll_last;

  lnk_us_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_load),
    .tick_o (us_tick)
  );

  lnk_wait_timer #(.W(TW)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (us_tick),
    .expired_o  (tmr_expired)
  );

  lnk_poll_counter #(.N_POLL(N_POLL)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    if (shutdown_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:     if (start_i) state_d = ST_CLK_PHY;
        ST_CLK_PHY:  state_d = ST_CLK_BUS;
        ST_CLK_BUS:  state_d = ST_CLK_CORE;
        ST_CLK_CORE: begin
          state_d  = ST_PD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_REF_US);
        end
        ST_PD_WAIT: if (tmr_expired) begin
          state_d  = ST_STABLE_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_STABLE_US);
        end
        ST_STABLE_WAIT: if (tmr_expired) begin
          state_d  = ST_PIN_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(T_PIN_US);
        end
        ST_PIN_WAIT: if (tmr_expired) begin
          tmr_load = 1'b1;
          if (lock_mode_i) begin
            state_d  = ST_LOCK_POLL;
            tmr_val  = TW'(T_POLL_US);
            poll_clr = 1'b1;
          end else begin
            state_d  = ST_SRST_WAIT;
            tmr_val  = TW'(T_SRST_US);
          end
        end
        ST_LOCK_POLL: if (tmr_expired) begin
          if (pll_locked_i) begin
            state_d = ST_DONE_LOCK;
          end else if (poll_last) begin
            state_d = ST_FAIL;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = TW'(T_POLL_US);
            poll_inc = 1'b1;
          end
        end
        ST_SRST_WAIT: if (tmr_expired) state_d = ST_DONE_SOFT;
        default: state_d = state_q;
      endcase
    end
  end

  assign out_d = decode_state(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      out_q   <= decode_state(ST_IDLE);
      pin_q   <= ~pin_pol_i;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      pin_q   <= out_d.pin_active ? pin_pol_i : ~pin_pol_i;
    end
  end

  assign phy_pwrdn_o    = out_q.phy_pwrdn;
  assign refclk_en_o    = out_q.refclk_en;
  assign phy_clk_en_o   = out_q.phy_clk_en;
  assign bus_clk_en_o   = out_q.bus_clk_en;
  assign core_clk_en_o  = out_q.core_clk_en;
  assign phy_rst_o      = out_q.phy_rst;
  assign core_srst_o    = out_q.core_srst;
  assign ep_rst_pin_o   = pin_q;
  assign done_o         = out_q.done;
  assign lock_timeout_o = out_q.lock_timeout;

endmodule

// File: rtl/lnk_pwrup_seq_chk.sv
module lnk_pwrup_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic shutdown_i,
  input logic pin_pol_i,
  input logic phy_pwrdn_o,
  input logic refclk_en_o,
  input logic phy_clk_en_o,
  input logic bus_clk_en_o,
  input logic core_clk_en_o,
  input logic phy_rst_o,
  input logic core_srst_o,
  input logic ep_rst_pin_o,
  input logic done_o,
  input logic lock_timeout_o
);

  // R2
  bus_after_phy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_clk_en_o) |-> phy_clk_en_o);

  // R2
  core_after_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en_o) |-> bus_clk_en_o);

  // R3
  ref_after_pwrup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(refclk_en_o) |-> (!phy_pwrdn_o && core_clk_en_o));

  // R4
  pin_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(pin_pol_i) && (ep_rst_pin_o == pin_pol_i)) |-> refclk_en_o);

  // R5
  pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!refclk_en_o && $stable(pin_pol_i)) |-> (ep_rst_pin_o == !pin_pol_i));

  // R8
  timeout_lock_only_chk: assert property (@(posedge clk) disable iff (rst)
    lock_timeout_o |-> (!phy_rst_o && core_srst_o && !done_o));

  // R9
  done_one_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phy_rst_o != core_srst_o));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !shutdown_i) |=> done_o);

  // R11
  shutdown_idle_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_i |=> (phy_pwrdn_o && !refclk_en_o && !phy_clk_en_o && !bus_clk_en_o &&
                    !core_clk_en_o && phy_rst_o && core_srst_o && !done_o && !lock_timeout_o));

  // R11
  shutdown_beats_start_chk: assert property (@(posedge clk) disable iff (rst)
    (shutdown_i && start_i) |=> !phy_clk_en_o);

endmodule

bind lnk_pwrup_seq lnk_pwrup_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .start_i        (start_i),
  .shutdown_i     (shutdown_i),
  .pin_pol_i      (pin_pol_i),
  .phy_pwrdn_o    (phy_pwrdn_o),
  .refclk_en_o    (refclk_en_o),
  .phy_clk_en_o   (phy_clk_en_o),
  .bus_clk_en_o   (bus_clk_en_o),
  .core_clk_en_o  (core_clk_en_o),
  .phy_rst_o      (phy_rst_o),
  .core_srst_o    (core_srst_o),
  .ep_rst_pin_o   (ep_rst_pin_o),
  .done_o         (done_o),
  .lock_timeout_o (lock_timeout_o)
);

// File: tb/lnk_pwrup_seq_test.sv
module lnk_pwrup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int TREF  = 2;
  localparam int TSTB  = 5;
  localparam int TPIN  = 7;
  localparam int TSRST = 3;
  localparam int TPOLL = 3;
  localparam int NPOLL = 4;
  localparam int TR  = TREF  * DIV + 1;
  localparam int TS  = TSTB  * DIV + 1;
  localparam int TP  = TPIN  * DIV + 1;
  localparam int TSR = TSRST * DIV + 1;
  localparam int TQ  = TPOLL * DIV + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, shutdown = 1'b0, pll_locked = 1'b0, pol = 1'b0, lock_mode = 1'b0;
  logic phy_pwrdn, refclk_en, phy_clk_en, bus_clk_en, core_clk_en;
  logic phy_rst, core_srst, ep_pin, done, lock_to;

  int n_chk = 0;
  int n_err = 0;
  bit summary_done = 1'b0;

  lnk_pwrup_seq #(
    .TICK_DIV(DIV), .T_REF_US(TREF), .T_STABLE_US(TSTB), .T_PIN_US(TPIN),
    .T_SRST_US(TSRST), .T_POLL_US(TPOLL), .N_POLL(NPOLL)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start), .shutdown_i(shutdown),
    .pll_locked_i(pll_locked), .pin_pol_i(pol), .lock_mode_i(lock_mode),
    .phy_pwrdn_o(phy_pwrdn), .refclk_en_o(refclk_en), .phy_clk_en_o(phy_clk_en),
    .bus_clk_en_o(bus_clk_en), .core_clk_en_o(core_clk_en), .phy_rst_o(phy_rst),
    .core_srst_o(core_srst), .ep_rst_pin_o(ep_pin), .done_o(done),
    .lock_timeout_o(lock_to)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Change stamps, written at falling edges
  int t_phy, t_bus, t_core, t_pd, t_ref, t_pon, t_poff, t_prst, t_srst, t_done, t_to;
  logic p_phy, p_bus, p_core, p_pd, p_ref, p_pin, p_prst, p_srst, p_done, p_to;
  bit mark_clr = 1'b0;

  always @(negedge clk) begin
    if (mark_clr) begin
      t_phy = -1; t_bus = -1; t_core = -1; t_pd = -1; t_ref = -1; t_pon = -1;
      t_poff = -1; t_prst = -1; t_srst = -1; t_done = -1; t_to = -1;
    end else begin
      if (phy_clk_en && !p_phy)   t_phy  = cyc;
      if (bus_clk_en && !p_bus)   t_bus  = cyc;
      if (core_clk_en && !p_core) t_core = cyc;
      if (!phy_pwrdn && p_pd)     t_pd   = cyc;
      if (refclk_en && !p_ref)    t_ref  = cyc;
      if (ep_pin == pol && p_pin != pol) t_pon = cyc;
      if (ep_pin != pol && p_pin == pol && t_pon >= 0) t_poff = cyc;
      if (!phy_rst && p_prst)     t_prst = cyc;
      if (!core_srst && p_srst)   t_srst = cyc;
      if (done && !p_done)        t_done = cyc;
      if (lock_to && !p_to)       t_to   = cyc;
    end
    p_phy = phy_clk_en; p_bus = bus_clk_en; p_core = core_clk_en; p_pd = phy_pwrdn;
    p_ref = refclk_en; p_pin = ep_pin; p_prst = phy_rst; p_srst = core_srst;
    p_done = done; p_to = lock_to;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
    $finish;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " phy_pwrdn"},   int'(phy_pwrdn), 1);
    chk({tag, " refclk_en"},   int'(refclk_en), 0);
    chk({tag, " phy_clk_en"},  int'(phy_clk_en), 0);
    chk({tag, " bus_clk_en"},  int'(bus_clk_en), 0);
    chk({tag, " core_clk_en"}, int'(core_clk_en), 0);
    chk({tag, " phy_rst"},     int'(phy_rst), 1);
    chk({tag, " core_srst"},   int'(core_srst), 1);
    chk({tag, " pin idle"},    int'(ep_pin), int'(!pol));
    chk({tag, " done"},        int'(done), 0);
    chk({tag, " timeout"},     int'(lock_to), 0);
  endtask

  function automatic int exp_poll_k(input int lofs);
    return lofs / TQ + 1;
  endfunction

  // One full sequence: mode, polarity, lock offset from release, stray start offset
  task automatic run_seq(input bit mode, input bit polv, input int lofs, input int inject);
    int s, e_phy, e_poff, e_done, e_to, k, end_cyc;
    lock_mode = mode; pol = polv; pll_locked = 1'b0;
    @(negedge clk); @(negedge clk);
    mark_clr = 1'b1; @(negedge clk); mark_clr = 1'b0;
    s = cyc; start = 1'b1;
    @(negedge clk); start = 1'b0;
    e_phy  = s + 1;
    e_poff = e_phy + 3 + TR + TS + TP;
    e_done = -1; e_to = -1;
    if (mode) begin
      k = exp_poll_k(lofs);
      if (k <= NPOLL) e_done = e_poff + k * TQ;
      else            e_to   = e_poff + NPOLL * TQ;
    end else begin
      e_done = e_poff + TSR;
    end
    end_cyc = ((e_done >= 0) ? e_done : e_to) + 3;
    while (cyc < end_cyc) begin
      if (mode && cyc == e_poff + lofs) pll_locked = 1'b1;
      start = (cyc == s + inject);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 phy clk edge",   t_phy,  e_phy);
    chk("R2 bus clk edge",   t_bus,  e_phy + 1);
    chk("R2 core clk edge",  t_core, e_phy + 2);
    chk("R3 pwrdn release",  t_pd,   e_phy + 3);
    chk("R3 refclk enable",  t_ref,  e_phy + 3 + TR);
    chk("R4 pin active",     t_pon,  e_phy + 3 + TR + TS);
    chk("R4 pin release",    t_poff, e_poff);
    chk("R5 pin level after release", int'(ep_pin), int'(!polv));
    if (mode) begin
      chk("R6 phy_rst release", t_prst, e_poff);
      chk("R6 core_srst held",  t_srst, -1);
      chk("R7 done edge",       t_done, e_done);
      chk("R8 timeout edge",    t_to,   e_to);
    end else begin
      chk("R9 core_srst release", t_srst, e_poff);
      chk("R9 phy_rst held",      t_prst, -1);
      chk("R9 done edge",         t_done, e_done);
      chk("R9 no timeout",        t_to,   -1);
    end
    // R10: stray start after completion leaves results untouched
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 done hold",    int'(done),    (e_done >= 0) ? 1 : 0);
    chk("R8 timeout hold",  int'(lock_to), (e_to >= 0) ? 1 : 0);
    // R11: shutdown returns to idle at the next edge
    shutdown = 1'b1; @(negedge clk); shutdown = 1'b0;
    check_idle("R11 shutdown");
    pll_locked = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    mark_clr = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0; mark_clr = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    // R5: pin polarity follows the config input
    pol = 1'b1; @(negedge clk);
    chk("R5 idle pin active-high cfg", int'(ep_pin), 0);
    pol = 1'b0; @(negedge clk);
    chk("R5 idle pin active-low cfg", int'(ep_pin), 1);

    // Directed corner cases
    run_seq(1'b1, 1'b0, 0, 5);                 // lock seen on first sample
    run_seq(1'b1, 1'b1, NPOLL * TQ + 20, 50);  // never locks: timeout
    run_seq(1'b1, 1'b1, (NPOLL - 1) * TQ + 2, 3); // lock on last sample
    run_seq(1'b0, 1'b1, 0, 40);                // soft mode, active-high pin
    run_seq(1'b0, 1'b0, 0, 12);                // soft mode, active-low pin

    // R11: shutdown mid-sequence, together with start
    lock_mode = 1'b0; pol = 1'b1;
    @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    shutdown = 1'b1; start = 1'b1; @(negedge clk);
    shutdown = 1'b0; start = 1'b0;
    check_idle("R11 mid-run");
    repeat (3) @(negedge clk);
    chk("R11 start overridden", int'(phy_clk_en), 0);

    // Random runs
    for (int i = 0; i < 8; i++) begin
      run_seq(1'($urandom % 2), 1'($urandom % 2),
              int'($urandom % (NPOLL * TQ + 8)), 2 + int'($urandom % 60));
    end

    summary();
  end

endmodule